// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin GPIO Port

This block is a general-purpose I/O port for 32 pins. Software reaches it over a plain register bus made of a byte address, a write enable, write data and combinational read data. Each pin can be an input or an output. An output drives the value held in the data register. Whatever the direction, the pin's input is brought through a two-flop synchroniser and can be read back.

Every pin also has an interrupt trigger. It can fire on a low level, a high level, a rising edge or a falling edge. A per-pin edge-select bit replaces that choice and makes the pin fire on both edges. Triggered pins set sticky status bits, which software clears by writing ones. The status bits are masked and then ORed onto two request lines, one for pins 0 to 15 and one for pins 16 to 31.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data (0x00), direction (0x04), trigger-config (0x0C, 0x10), mask (0x14) and edge-select (0x1C) registers read 0, every output enable is 0 and both interrupt lines are 0.
- R2: `padOut` carries the data register and `padOutEn` carries the direction register, where a 1 means output. A read of offset 0x00 returns the last value written there, not the pad level.
- R3: Offset 0x08 returns the synchronised pad inputs whatever the direction. A pad change is still invisible at the first clock edge and is readable after the second. Writes to 0x08 have no effect.
- R4: Pin n takes its 2-bit trigger code from bits [2·(n mod 16)+1 : 2·(n mod 16)]. Pins 0 to 15 use the register at 0x0C and pins 16 to 31 use the register at 0x10.
- R5: Code 00 triggers on a low level and code 01 on a high level. A level trigger sets the status bit on every cycle the level holds.
- R6: Code 10 triggers on a rising edge and code 11 on a falling edge. An edge is found by comparing the synchronised input with its value one cycle earlier.
- R7: When a pin's edge-select bit (offset 0x1C, bit n) is 1, the pin triggers on both edges and its 2-bit code is ignored.
- R8: Writing a 1 to bit n of the status register (offset 0x18) clears that bit. Writing a 0 leaves it unchanged.
- R9: When a trigger and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: `irqLow` is the OR over pins 0 to 15 of status AND mask, and `irqHigh` is the same over pins 16 to 31. A mask bit (offset 0x14) of 1 enables its pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | 5 | Byte address of the register |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| padIn | input | 32 | Raw pad inputs |
| padOut | output | 32 | Pad output values |
| padOutEn | output | 32 | Pad output enables |
| irqLow | output | 1 | Request for pins 0 to 15 |
| irqHigh | output | 1 | Request for pins 16 to 31 |

## Verification
The hardest case to reach is a software clear that lands in the same cycle as a hardware set. The bench gets there by holding a pin at its configured active level, so that a level trigger re-fires on every cycle. Any write-one-to-clear then collides with a set, and the status must read back as still set.

The second case is a pin whose 2-bit code would fire on its own. The bench sets up such a pin, turns on its edge-select bit, clears the status and holds the pad steady. The status must stay clear, which shows the code is ignored.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_EDGE   = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrCfgLo;
    logic wrCfgHi;
    logic wrMask;
    logic wrStatClr;
    logic wrEdge;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stageQ[s] <= '0;
          else        stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output wrStrobe_t         strobe,
  output regSel_e           rdSel
);

  localparam int IDX_LSB = 2;

  regSel_e idx;

  assign idx   = regSel_e'(busAddr[IDX_LSB +: REG_IDX_W]);
  assign rdSel = idx;

  always_comb begin
    strobe = '0;
    if (busWrEn) begin
      unique case (idx)
        REG_DATA:   strobe.wrData    = 1'b1;
        REG_DIR:    strobe.wrDir     = 1'b1;
        REG_CFG_LO: strobe.wrCfgLo   = 1'b1;
        REG_CFG_HI: strobe.wrCfgHi   = 1'b1;
        REG_MASK:   strobe.wrMask    = 1'b1;
        REG_STAT:   strobe.wrStatClr = 1'b1;
        REG_EDGE:   strobe.wrEdge    = 1'b1;
        default:    strobe           = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_dpath.sv
module gpio_irq_dpath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wrStrobe_t           strobe,
  input  regSel_e             rdSel,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic                irqLow,
  output logic                irqHigh
);

  localparam int HALF  = NUM_PINS / 2;
  localparam int CFG_W = 2 * HALF;

  logic [NUM_PINS-1:0] dataQ, dirQ, maskQ, statQ, edgeQ, prevQ;
  logic [CFG_W-1:0]    cfgLoQ, cfgHiQ;
  logic [NUM_PINS-1:0] padSync, setVec, clrVec, statD;

  gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (padIn),
    .syncOut (padSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dataQ  <= '0;
      dirQ   <= '0;
      cfgLoQ <= '0;
      cfgHiQ <= '0;
      maskQ  <= '0;
      edgeQ  <= '0;
      statQ  <= '0;
      prevQ  <= '0;
    end else begin
      if (strobe.wrData)  dataQ  <= wrData;
      if (strobe.wrDir)   dirQ   <= wrData;
      if (strobe.wrCfgLo) cfgLoQ <= wrData;
      if (strobe.wrCfgHi) cfgHiQ <= wrData;
      if (strobe.wrMask)  maskQ  <= wrData;
      if (strobe.wrEdge)  edgeQ  <= wrData;
      statQ <= statD;
      prevQ <= padSync;
    end
  end

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      trig_e code;
      if (p < HALF) begin : g_lo
        assign code = trig_e'(cfgLoQ[2*p +: 2]);
      end else begin : g_hi
        assign code = trig_e'(cfgHiQ[2*(p-HALF) +: 2]);
      end

      always_comb begin
        if (edgeQ[p]) begin
          setVec[p] = padSync[p] ^ prevQ[p];
        end else begin
          unique case (code)
            TRIG_LOW:  setVec[p] = ~padSync[p];
            TRIG_HIGH: setVec[p] =  padSync[p];
            TRIG_RISE: setVec[p] =  padSync[p] & ~prevQ[p];
            TRIG_FALL: setVec[p] = ~padSync[p] &  prevQ[p];
            default:   setVec[p] = 1'b0;
          endcase
        end
      end
    end
  endgenerate

  assign clrVec = strobe.wrStatClr ? wrData : '0;
  assign statD  = (statQ & ~clrVec) | setVec;

  always_comb begin
    unique case (rdSel)
      REG_DATA:   rdData = dataQ;
      REG_DIR:    rdData = dirQ;
      REG_PAD:    rdData = padSync;
      REG_CFG_LO: rdData = cfgLoQ;
      REG_CFG_HI: rdData = cfgHiQ;
      REG_MASK:   rdData = maskQ;
      REG_STAT:   rdData = statQ;
      REG_EDGE:   rdData = edgeQ;
      default:    rdData = '0;
    endcase
  end

  assign padOut   = dataQ;
  assign padOutEn = dirQ;
  assign irqLow   = |(statQ[HALF-1:0] & maskQ[HALF-1:0]);
  assign irqHigh  = |(statQ[NUM_PINS-1:HALF] & maskQ[NUM_PINS-1:HALF]);

  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(statQ) & ~statQ) & ~$past(clrVec)) == '0)); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(setVec) & ~statQ) == '0)); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (maskQ == '0) |-> (!irqLow && !irqHigh)); // R10

  AST_DIR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrDir |=> (padOutEn == $past(wrData))); // R2

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOutEn,
  output logic                irqLow,
  output logic                irqHigh
);

  gpio_irq_pkg::wrStrobe_t strobe;
  gpio_irq_pkg::regSel_e   rdSel;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_irq_dpath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOutEn (padOutEn),
    .irqLow   (irqLow),
    .irqHigh  (irqHigh)
  );

endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOutEn;
  logic        irqLow, irqHigh;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_PAD = 5'h08,
                         A_CFGL = 5'h0C, A_CFGH = 5'h10, A_MASK = 5'h14,
                         A_STAT = 5'h18, A_EDGE = 5'h1C;
  localparam logic [31:0] ALL_RISE = 32'hAAAA_AAAA;

  always #2 clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOutEn(padOutEn), .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setPad(logic [31:0] v);
    @(negedge clk);
    padIn = v;
    idle(4);
  endtask

  task automatic test_reset;
    logic [31:0] r;
    rdReg(A_DATA, r); check("R1 data", r, 0);
    rdReg(A_DIR,  r); check("R1 dir", r, 0);
    rdReg(A_CFGL, r); check("R1 cfgLo", r, 0);
    rdReg(A_CFGH, r); check("R1 cfgHi", r, 0);
    rdReg(A_MASK, r); check("R1 mask", r, 0);
    rdReg(A_EDGE, r); check("R1 edgeSel", r, 0);
    check("R1 padOutEn", padOutEn, 0);
    check("R1 irq", {30'd0, irqHigh, irqLow}, 0);
  endtask

  task automatic setup_quiet;
    logic [31:0] r;
    wrReg(A_CFGL, ALL_RISE);
    wrReg(A_CFGH, ALL_RISE);
    wrReg(A_STAT, 32'hFFFF_FFFF);
    rdReg(A_STAT, r); check("R8 clear all", r, 0);
  endtask

  task automatic test_data_dir;
    logic [31:0] r;
    wrReg(A_DATA, 32'hA5A5_0F0F);
    wrReg(A_DIR,  32'hFFFF_0000);
    check("R2 padOut", padOut, 32'hA5A5_0F0F);
    check("R2 padOutEn", padOutEn, 32'hFFFF_0000);
    rdReg(A_DATA, r); check("R2 data readback not pad", r, 32'hA5A5_0F0F);
    wrReg(A_DIR, 0);
  endtask

  task automatic test_pad_status;
    logic [31:0] r;
    @(negedge clk);
    busAddr = A_PAD;
    padIn = 32'h1234_8001;
    @(negedge clk); #1 check("R3 one edge still old", busRdData, 0);
    @(negedge clk); #1 check("R3 two edges visible", busRdData, 32'h1234_8001);
    wrReg(A_PAD, 32'hFFFF_FFFF);
    rdReg(A_PAD, r); check("R3 write ignored", r, 32'h1234_8001);
    setPad(0);
    wrReg(A_STAT, 32'hFFFF_FFFF);
  endtask

  task automatic test_edges;
    logic [31:0] r;
    wrReg(A_CFGH, 32'hAAAA_ABAA);
    wrReg(A_MASK, 32'h0010_0004);
    setPad(32'h0010_0000);
    rdReg(A_STAT, r); check("R6 falling pin ignores rise", r, 0);
    check("R10 irqHigh quiet", {31'd0, irqHigh}, 0);
    setPad(0);
    rdReg(A_STAT, r); check("R6 falling edge pin20", r, 32'h0010_0000);
    check("R10 irqHigh", {31'd0, irqHigh}, 1);
    check("R10 irqLow quiet", {31'd0, irqLow}, 0);
    wrReg(A_MASK, 32'h0000_0010);
    check("R10 masked irqHigh", {31'd0, irqHigh}, 0);
    wrReg(A_STAT, 32'hFFFF_FFFF);
    wrReg(A_MASK, 32'h0000_0004);
    setPad(32'h0000_0004);
    rdReg(A_STAT, r); check("R6 rising pin2", r, 32'h0000_0004);
    check("R10 irqLow", {31'd0, irqLow}, 1);
    wrReg(A_STAT, 32'h0000_0000);
    rdReg(A_STAT, r); check("R8 write 0 keeps", r, 32'h0000_0004);
    wrReg(A_STAT, 32'h0000_0004);
    rdReg(A_STAT, r); check("R8 write 1 clears", r, 0);
    setPad(0);
    rdReg(A_STAT, r); check("R6 no fire on fall for rise pin", r, 0);
    wrReg(A_CFGH, ALL_RISE);
    wrReg(A_MASK, 0);
  endtask

  task automatic test_levels;
    logic [31:0] r;
    wrReg(A_CFGL, 32'hAAAA_A6AA);
    setPad(32'h0000_0020);
    wrReg(A_STAT, 32'h0000_0020);
    rdReg(A_STAT, r); check("R9 R5 high level survives clear", r, 32'h0000_0020);
    setPad(0);
    wrReg(A_STAT, 32'h0000_0020);
    rdReg(A_STAT, r); check("R5 level gone clears", r, 0);
    wrReg(A_CFGL, ALL_RISE);
    wrReg(A_CFGH, 32'hAAAA_AAA2);
    idle(2);
    rdReg(A_STAT, r); check("R4 R5 low level pin17 only", r, 32'h0002_0000);
    wrReg(A_CFGH, ALL_RISE);
    wrReg(A_STAT, 32'hFFFF_FFFF);
    rdReg(A_STAT, r); check("R5 cleared after restore", r, 0);
  endtask

  task automatic test_edge_sel;
    logic [31:0] r;
    wrReg(A_EDGE, 32'h0000_0008);
    setPad(32'h0000_0008);
    rdReg(A_STAT, r); check("R7 both edges rise", r, 32'h0000_0008);
    wrReg(A_STAT, 32'hFFFF_FFFF);
    setPad(0);
    rdReg(A_STAT, r); check("R7 both edges fall", r, 32'h0000_0008);
    wrReg(A_CFGL, 32'hAAAA_AA2A);
    wrReg(A_STAT, 32'hFFFF_FFFF);
    idle(3);
    rdReg(A_STAT, r); check("R7 low-level code ignored", r, 0);
    wrReg(A_CFGL, ALL_RISE);
    wrReg(A_EDGE, 0);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    test_reset;
    setup_quiet;
    test_data_dir;
    test_pad_status;
    test_edges;
    test_levels;
    test_edge_sel;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule